// File: doc/BRIEF.md
# Cell PHY Control and Interrupt Register Block

This block is the small register file that sits beside a cell-based transmission-convergence core. A byte-wide utility bus (address, write data, write strobe, read strobe, registered read data) reaches two registers: a control register at address 0x00 and an interrupt status register at address 0x01. The control register drives configuration levels into the cell datapath. These cover discarding errored or idle cells, transmit parity checking, halting the transmitter and choosing between cell and byte transfer mode. It also holds the interrupt enable and an interrupt qualifier.

The datapath reports events as single-cycle pulses: a received-cell error and a change in signal quality. Each pulse is latched into a sticky status bit. The bit is cleared as a side effect of reading the status register. A pulse that arrives in the same cycle as that read survives it. The status register also shows the present signal-quality level as a read-only bit. The active-low interrupt output is gated by the interrupt enable. It can be narrowed so that only the received-cell-error bit drives it. Gating never alters what the status register records.

Top module: `cellPhyRegs`

## Requirements
- R1: After reset every control bit is 0, every sticky status bit is 0, the read data is 0x00 and irqN is high.
- R2: A write to address 0x00 loads the control register, and the control outputs follow one cycle later. The field positions are: bit0 interrupt enable, bit1 cell-error-only qualifier, bit2 drop errored cells, bit3 transmit parity check, bit4 drop idle cells, bit5 halt transmit, bit6 byte mode (0 = cell mode). A read of 0x00 returns these bits.
- R3: Bit 7 of the control register is reserved. It reads as 0, and writing 1 to it has no effect.
- R4: An event pulse sets its sticky bit at the next clock edge whatever the interrupt enable holds. Received-cell error goes to status bit0 and signal-quality change goes to status bit1.
- R5: A read of 0x01 returns, one cycle later, the sticky bits in bits 1:0, the live signal-quality level in bit7 (1 = good, 0 = bad) and 0 in bits 6:2. The same read clears the sticky bits.
- R6: An event pulse that coincides with a status read leaves its bit set after that read.
- R7: With the interrupt enable at 0, irqN stays high whatever the status bits hold.
- R8: With the interrupt enable at 1 and the qualifier at 0, irqN is low exactly while any sticky bit is set.
- R9: With the interrupt enable at 1 and the qualifier at 1, only status bit0 can pull irqN low. A set signal-change bit leaves irqN high.
- R10: Writes to the status address or to an unmapped address change no register. A read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Utility bus address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, valid the cycle after busRdEn |
| evtCellErr | input | 1 | Received-cell error pulse |
| evtSigChange | input | 1 | Signal-quality change pulse |
| sigGood | input | 1 | Present signal-quality level, 1 = good |
| irqN | output | 1 | Active-low interrupt |
| ctrlDropErr | output | 1 | Discard errored received cells |
| ctrlTxParity | output | 1 | Enable transmit data parity check |
| ctrlDropIdle | output | 1 | Discard received idle cells |
| ctrlHaltTx | output | 1 | Halt transmission, force line data to 0 |
| ctrlByteMode | output | 1 | 0 = cell transfer mode, 1 = byte mode |

## Verification
The bench builds the block with its defaults: a 4-bit address, the control register at 0 and the status register at 1. That leaves fourteen unmapped addresses. Two of them, 5 and 15, are used to show that stray writes are dropped and stray reads return zero. The defaults also put the two sticky bits where both interrupt qualifications can be driven independently. This includes the case where an event pulse lands in the same cycle as the clearing read.

// File: rtl/cellPhyRegsPkg.sv
package cellPhyRegsPkg;

  localparam int DATA_W      = 8;
  localparam int NUM_STICKY  = 2;
  localparam int STK_CELLERR = 0;
  localparam int STK_SIGCHG  = 1;
  localparam int SIGGOOD_BIT = 7;

  // Packed MSB first: intEnable lands on bit 0.
  typedef struct packed {
    logic byteMode;
    logic haltTx;
    logic dropIdle;
    logic txParity;
    logic dropErr;
    logic errOnlyIrq;
    logic intEnable;
  } ctrlFields_t;

  localparam int CTRL_W = $bits(ctrlFields_t);

  typedef struct packed {
    logic wrCtrl;
    logic rdCtrl;
    logic rdStat;
    logic rdOther;
  } busStrobe_t;

endpackage

// File: rtl/cellPhyBusDecode.sv
module cellPhyBusDecode
  import cellPhyRegsPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

  logic hitCtrl;
  logic hitStat;

  always_comb begin
    hitCtrl        = (busAddr == CtrlA);
    hitStat        = (busAddr == StatA);
    strobe.wrCtrl  = busWrEn && hitCtrl;
    strobe.rdCtrl  = busRdEn && hitCtrl;
    strobe.rdStat  = busRdEn && hitStat;
    strobe.rdOther = busRdEn && !hitCtrl && !hitStat;
  end

  // R10: every read falls into exactly one read target
  always_comb begin
    if (!$isunknown({busRdEn, busAddr})) begin
      a_r10_one_read_target: assert (!busRdEn || $onehot({strobe.rdCtrl, strobe.rdStat, strobe.rdOther}));
      a_r10_no_read_when_idle: assert (busRdEn || !(|{strobe.rdCtrl, strobe.rdStat, strobe.rdOther}));
    end
  end

endmodule

// File: rtl/cellPhyRegFile.sv
module cellPhyRegFile
  import cellPhyRegsPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            strobe,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_STICKY-1:0] evtIn,
  input  logic                  sigGood,
  output ctrlFields_t           ctrlOut,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irqN
);

  ctrlFields_t           ctrlReg;
  logic [NUM_STICKY-1:0] stickyQ;
  logic [NUM_STICKY-1:0] qualMask;
  logic [DATA_W-1:0]     statWord;
  logic [DATA_W-1:0]     rdNext;
  logic                  irqActive;

  // Control register; reserved upper bits are not stored
  always_ff @(posedge clk) begin
    if (!rstN)              ctrlReg <= '0;
    else if (strobe.wrCtrl) ctrlReg <= ctrlFields_t'(wrData[CTRL_W-1:0]);
  end

  // Sticky bits: the read clears, a same-cycle event wins
  for (genvar i = 0; i < NUM_STICKY; i++) begin : gStk
    always_ff @(posedge clk) begin
      if (!rstN) stickyQ[i] <= 1'b0;
      else       stickyQ[i] <= (stickyQ[i] && !strobe.rdStat) || evtIn[i];
    end

    // R4
    a_r4_event_latches: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> stickyQ[i]);
    // R5
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rdStat && !evtIn[i]) |=> !stickyQ[i]);
    // R6
    a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rdStat && evtIn[i]) |=> stickyQ[i]);
    a_r5_holds_until_read: assert property (@(posedge clk) disable iff (!rstN)
      (stickyQ[i] && !strobe.rdStat) |=> stickyQ[i]);
  end

  // Read path
  always_comb begin
    statWord              = '0;
    statWord[NUM_STICKY-1:0] = stickyQ;
    statWord[SIGGOOD_BIT] = sigGood;
    rdNext = '0;
    if (strobe.rdCtrl)      rdNext = DATA_W'(ctrlReg);
    else if (strobe.rdStat) rdNext = statWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdCtrl || strobe.rdStat || strobe.rdOther) rdData <= rdNext;
  end

  // Interrupt output
  always_comb begin
    qualMask = '1;
    if (ctrlReg.errOnlyIrq) begin
      qualMask              = '0;
      qualMask[STK_CELLERR] = 1'b1;
    end
    irqActive = ctrlReg.intEnable && (|(stickyQ & qualMask));
    irqN      = !irqActive;
  end

  assign ctrlOut = ctrlReg;

  // R2
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCtrl |=> (ctrlReg == $past(wrData[CTRL_W-1:0])));
  // R10
  a_r10_ctrl_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCtrl |=> $stable(ctrlReg));
  // R7
  a_r7_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOut.intEnable |-> irqN);
  // R9
  a_r9_cellerr_only: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut.intEnable && ctrlOut.errOnlyIrq && !stickyQ[STK_CELLERR]) |-> irqN);
  // R8
  a_r8_any_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut.intEnable && !ctrlOut.errOnlyIrq && (|stickyQ)) |-> !irqN);

endmodule

// File: rtl/cellPhyRegs.sv
module cellPhyRegs
  import cellPhyRegsPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [7:0]        busRdData,
  input  logic              evtCellErr,
  input  logic              evtSigChange,
  input  logic              sigGood,
  output logic              irqN,
  output logic              ctrlDropErr,
  output logic              ctrlTxParity,
  output logic              ctrlDropIdle,
  output logic              ctrlHaltTx,
  output logic              ctrlByteMode
);

  busStrobe_t            strobe;
  ctrlFields_t           ctrlVal;
  logic [NUM_STICKY-1:0] evtVec;

  always_comb begin
    evtVec              = '0;
    evtVec[STK_CELLERR] = evtCellErr;
    evtVec[STK_SIGCHG]  = evtSigChange;
  end

  cellPhyBusDecode #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) decode_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  cellPhyRegFile regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWrData),
    .evtIn   (evtVec),
    .sigGood (sigGood),
    .ctrlOut (ctrlVal),
    .rdData  (busRdData),
    .irqN    (irqN)
  );

  assign ctrlDropErr  = ctrlVal.dropErr;
  assign ctrlTxParity = ctrlVal.txParity;
  assign ctrlDropIdle = ctrlVal.dropIdle;
  assign ctrlHaltTx   = ctrlVal.haltTx;
  assign ctrlByteMode = ctrlVal.byteMode;

endmodule

// File: tb/cellPhyRegs_tb_top.sv
module cellPhyRegs_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       evtCellErr = 1'b0;
  logic       evtSigChange = 1'b0;
  logic       sigGood = 1'b1;
  logic       irqN;
  logic       ctrlDropErr, ctrlTxParity, ctrlDropIdle, ctrlHaltTx, ctrlByteMode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cellPhyRegs dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .evtCellErr(evtCellErr), .evtSigChange(evtSigChange), .sigGood(sigGood),
    .irqN(irqN), .ctrlDropErr(ctrlDropErr), .ctrlTxParity(ctrlTxParity),
    .ctrlDropIdle(ctrlDropIdle), .ctrlHaltTx(ctrlHaltTx), .ctrlByteMode(ctrlByteMode)
  );

  // Vector: {op[1:0], addr[3:0], data[7:0], expect[7:0]}; op 1 = write, 2 = read and compare
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 4'd0, 8'h7F, 8'h00},  // R2 write all fields
    {2'd2, 4'd0, 8'h00, 8'h7F},  // R2
    {2'd1, 4'd0, 8'hFF, 8'h00},  // R3 reserved bit
    {2'd2, 4'd0, 8'h00, 8'h7F},  // R3
    {2'd1, 4'd1, 8'hFF, 8'h00},  // R10 write to status
    {2'd2, 4'd0, 8'h00, 8'h7F},  // R10
    {2'd2, 4'd1, 8'h00, 8'h80},  // R5 status with no events
    {2'd1, 4'd5, 8'h00, 8'h00},  // R10 unmapped write
    {2'd2, 4'd0, 8'h00, 8'h7F},  // R10
    {2'd2, 4'd5, 8'h00, 8'h00},  // R10 unmapped read
    {2'd1, 4'd15, 8'h12, 8'h00}, // R10
    {2'd2, 4'd15, 8'h00, 8'h00}, // R10
    {2'd1, 4'd0, 8'h2A, 8'h00},  // R2 pattern
    {2'd2, 4'd0, 8'h00, 8'h2A},  // R2
    {2'd1, 4'd0, 8'h55, 8'h00},  // R2 pattern
    {2'd2, 4'd0, 8'h00, 8'h55}   // R2
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic pulse(input bit cellErr, input bit sigChg);
    @(negedge clk);
    evtCellErr = cellErr; evtSigChange = sigChg;
    @(negedge clk);
    evtCellErr = 1'b0; evtSigChange = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqN", {7'd0, irqN}, 8'h01);
    check("R1 ctrl outputs", {3'd0, ctrlDropErr, ctrlTxParity, ctrlDropIdle, ctrlHaltTx, ctrlByteMode}, 8'h00);
    check("R1 rdData", busRdData, 8'h00);
    busRead(4'd0, rd); check("R1 ctrl reg", rd, 8'h00);
    busRead(4'd1, rd); check("R1 status", rd, 8'h80);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21:20] == 2'd1) busWrite(VEC[i][19:16], VEC[i][15:8]);
      else begin
        busRead(VEC[i][19:16], rd);
        check($sformatf("R2/R3/R5/R10 vector %0d", i), rd, VEC[i][7:0]);
      end
    end

    // R2 field positions at the outputs
    busWrite(4'd0, 8'h7C);
    check("R2 outputs", {3'd0, ctrlDropErr, ctrlTxParity, ctrlDropIdle, ctrlHaltTx, ctrlByteMode}, 8'h1F);
    busWrite(4'd0, 8'h24);
    check("R2 outputs haltTx+dropErr", {3'd0, ctrlDropErr, ctrlTxParity, ctrlDropIdle, ctrlHaltTx, ctrlByteMode}, 8'h12);

    // R4, R7: interrupts disabled, events still latch
    busWrite(4'd0, 8'h00);
    pulse(1'b1, 1'b0);
    check("R7 irqN masked", {7'd0, irqN}, 8'h01);
    busRead(4'd1, rd); check("R4 cellErr latched", rd, 8'h81);
    busRead(4'd1, rd); check("R5 cleared by read", rd, 8'h80);
    sigGood = 1'b0;
    pulse(1'b0, 1'b1);
    check("R7 irqN masked sigchg", {7'd0, irqN}, 8'h01);
    busRead(4'd1, rd); check("R5 bad signal + sigchg", rd, 8'h02);
    sigGood = 1'b1;

    // R9: qualifier set
    busWrite(4'd0, 8'h03);
    pulse(1'b0, 1'b1);
    check("R9 sigchg ignored", {7'd0, irqN}, 8'h01);
    pulse(1'b1, 1'b0);
    check("R9 cellErr asserts", {7'd0, irqN}, 8'h00);
    busRead(4'd1, rd); check("R5 both bits", rd, 8'h83);
    check("R9 irqN released", {7'd0, irqN}, 8'h01);

    // R8: any sticky bit
    busWrite(4'd0, 8'h01);
    pulse(1'b0, 1'b1);
    check("R8 sigchg asserts", {7'd0, irqN}, 8'h00);
    busRead(4'd1, rd);
    check("R8 irqN released", {7'd0, irqN}, 8'h01);

    // R6: event coincides with clearing read
    @(negedge clk);
    busAddr = 4'd1; busRdEn = 1'b1; evtCellErr = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0; evtCellErr = 1'b0;
    check("R6 read returns prior", busRdData, 8'h80);
    check("R6 irq still low", {7'd0, irqN}, 8'h00);
    busRead(4'd1, rd); check("R6 bit survived", rd, 8'h81);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule